// File: doc/BRIEF.md
# UART Control and Status Register File

This block is the bus-facing front end of a UART. It gives software eight 32-bit registers at word addresses and a level interrupt whose cause can be read back as a three-bit identification code. Transmit bytes go out toward a serializer, and received bytes come in from a deserializer. Bit timing, baud generation and modem-pin sampling are done elsewhere. The configuration registers are brought out as ports for that logic, and the modem status arrives as an input vector.

Writing the data register sends a byte out on a one-cycle transmit strobe. A received byte is held in the data register and raises data-ready. Reading the data register clears data-ready. If a byte arrives while data-ready is still set, the new byte replaces the old one and the overrun flag is set. The parity, framing and break flags are set by strobes from the deserializer. Overrun, parity, framing and break all stay set until reset.

Top module: `uart_regfile`

## Requirements
- R1: After reset the line-status register reads 0x60, the identification register reads 0x1, `irq` is low, `rx_ready` is high and `line_ctrl`, `modem_ctrl`, `divisor` are zero.
- R2: The write-only registers read back as zero. They are interrupt-enable (word 1, bits [3:0]), line-control (word 3, bits [7:0] to `line_ctrl`), modem-control (word 4, bits [7:0] to `modem_ctrl`) and divisor (word 7, bits [15:0] to `divisor`).
- R3: A write to word 0 asserts `tx_valid` for exactly one cycle, in the cycle after the write, with `tx_data` equal to write bits [7:0]. No other access asserts `tx_valid`.
- R4: A received byte sets data-ready (line-status bit 0) and drops `rx_ready`. A read of word 0 returns the byte in bits [7:0] and clears data-ready, which raises `rx_ready` again.
- R5: A byte received while data-ready is set also sets overrun (line-status bit 1), and the data register then holds the newer byte.
- R6: The error flags are overrun (bit 1), parity (bit 2, from `rx_parity_err`), framing (bit 3, from `rx_frame_err`) and break (bit 4, from `rx_break`). They stay set until reset, and reads do not clear them. Bits 5 and 6 (transmit-holding-empty, transmitter-empty) always read as 1.
- R7: Writes to words 2, 5 and 6 (identification, line-status, modem-status) change nothing.
- R8: The identification code (word 2, bits [2:0]) is chosen by priority, highest first:
  - 0b110 when any error flag is set and enable bit 2 is set;
  - 0b100 when data-ready is set and enable bit 0 is set;
  - 0b010 when enable bit 1 is set (transmit-holding-empty is always set);
  - 0b000 when any of `modem_status[3:0]` is set and enable bit 3 is set;
  - 0b001 otherwise.
- R9: `irq` is high exactly when the identification code is not 0b001. It follows every register write and every received byte in the next cycle.
- R10: A read of word 6 returns `modem_status` in bits [7:0].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 3 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid while `bus_rd` is high, zero otherwise |
| irq | output | 1 | Level interrupt |
| tx_valid | output | 1 | Transmit byte strobe |
| tx_data | output | 8 | Transmit byte |
| rx_valid | input | 1 | Received byte strobe |
| rx_data | input | 8 | Received byte |
| rx_ready | output | 1 | High while data-ready is clear |
| rx_parity_err | input | 1 | Parity error strobe |
| rx_frame_err | input | 1 | Framing error strobe |
| rx_break | input | 1 | Break detected strobe |
| modem_status | input | 8 | Modem status vector |
| line_ctrl | output | 8 | Line-control register |
| modem_ctrl | output | 8 | Modem-control register |
| divisor | output | 16 | Divisor register |

## Verification
A lost or stuck data-ready bit appears one cycle after the triggering byte or read, both on `rx_ready` and in bit 0 of a line-status read. A sticky flag that drops early, or an overrun that is missed, appears on the next line-status read. When the enable bit for line status is set, it also appears at once in the identification code and on `irq`. A wrong priority order only appears when two causes are pending together, so the stimulus stacks data-ready, overrun and transmit-empty before it reads the code.

// File: rtl/uart_rf_pkg.sv
package uart_rf_pkg;
  localparam logic [2:0] A_DATA = 3'd0;
  localparam logic [2:0] A_IEN  = 3'd1;
  localparam logic [2:0] A_IID  = 3'd2;
  localparam logic [2:0] A_LCTL = 3'd3;
  localparam logic [2:0] A_MCTL = 3'd4;
  localparam logic [2:0] A_LST  = 3'd5;
  localparam logic [2:0] A_MST  = 3'd6;
  localparam logic [2:0] A_DIV  = 3'd7;

  localparam int unsigned EN_RXD = 0;
  localparam int unsigned EN_THR = 1;
  localparam int unsigned EN_LIN = 2;
  localparam int unsigned EN_MDM = 3;
  localparam int unsigned EN_W   = 4;

  localparam int unsigned LS_W   = 7;

  typedef enum logic [2:0] {
    ID_LINE = 3'b110,
    ID_RXD  = 3'b100,
    ID_THR  = 3'b010,
    ID_MDM  = 3'b000,
    ID_NONE = 3'b001
  } irq_id_e;
endpackage

// File: rtl/uart_rf_ctrl.sv
module uart_rf_ctrl
  import uart_rf_pkg::*;
#(
  parameter int unsigned BYTE_W = 8,
  parameter int unsigned DIV_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [2:0]        addr,
  input  logic [DIV_W-1:0]  wdata,
  output logic [EN_W-1:0]   ien,
  output logic [BYTE_W-1:0] lctl,
  output logic [BYTE_W-1:0] mctl,
  output logic [DIV_W-1:0]  div
);
  logic ien_en, lctl_en, mctl_en, div_en;

  always_comb begin
    ien_en  = wr && (addr == A_IEN);
    lctl_en = wr && (addr == A_LCTL);
    mctl_en = wr && (addr == A_MCTL);
    div_en  = wr && (addr == A_DIV);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ien  <= '0;
      lctl <= '0;
      mctl <= '0;
      div  <= '0;
    end else begin
      if (ien_en)  ien  <= wdata[EN_W-1:0];
      if (lctl_en) lctl <= wdata[BYTE_W-1:0];
      if (mctl_en) mctl <= wdata[BYTE_W-1:0];
      if (div_en)  div  <= wdata;
    end
  end
endmodule

// File: rtl/uart_rf_rx.sv
module uart_rf_rx
  import uart_rf_pkg::*;
#(
  parameter int unsigned BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_valid,
  input  logic [BYTE_W-1:0] rx_data,
  input  logic              pe_stb,
  input  logic              fe_stb,
  input  logic              brk_stb,
  input  logic              data_rd,
  output logic [BYTE_W-1:0] hold,
  output logic [LS_W-1:0]   lst
);
  localparam int unsigned NERR = 4;

  logic            dr_q, dr_d;
  logic [NERR-1:0] err_q, err_d, err_set;
  logic            err_en;

  // Error set vector in line-status order: overrun, parity, framing, break
  always_comb begin
    err_set = {brk_stb, fe_stb, pe_stb, rx_valid & dr_q};
    err_en  = |err_set;
    err_d   = err_q | err_set;
    if (rx_valid)     dr_d = 1'b1;
    else if (data_rd) dr_d = 1'b0;
    else              dr_d = dr_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dr_q  <= 1'b0;
      err_q <= '0;
      hold  <= '0;
    end else begin
      dr_q <= dr_d;
      if (err_en)   err_q <= err_d;
      if (rx_valid) hold  <= rx_data;
    end
  end

  // Transmit-holding-empty and transmitter-empty are constant ones here
  assign lst = {2'b11, err_q, dr_q};
endmodule

// File: rtl/uart_rf_irq.sv
module uart_rf_irq
  import uart_rf_pkg::*;
(
  input  logic [EN_W-1:0] ien,
  input  logic [LS_W-1:0] lst,
  input  logic [3:0]      mdm_delta,
  output irq_id_e         id,
  output logic            irq
);
  logic line_hit, rxd_hit, thr_hit, mdm_hit;

  always_comb begin
    line_hit = (|lst[4:1]) && ien[EN_LIN];
    rxd_hit  = lst[0] && ien[EN_RXD];
    thr_hit  = lst[5] && ien[EN_THR];
    mdm_hit  = (|mdm_delta) && ien[EN_MDM];
    if (line_hit)     id = ID_LINE;
    else if (rxd_hit) id = ID_RXD;
    else if (thr_hit) id = ID_THR;
    else if (mdm_hit) id = ID_MDM;
    else              id = ID_NONE;
    irq = line_hit | rxd_hit | thr_hit | mdm_hit;
  end
endmodule

// File: rtl/uart_regfile.sv
module uart_regfile
  import uart_rf_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned BYTE_W = 8,
  parameter int unsigned DIV_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [2:0]        bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq,
  output logic              tx_valid,
  output logic [BYTE_W-1:0] tx_data,
  input  logic              rx_valid,
  input  logic [BYTE_W-1:0] rx_data,
  output logic              rx_ready,
  input  logic              rx_parity_err,
  input  logic              rx_frame_err,
  input  logic              rx_break,
  input  logic [BYTE_W-1:0] modem_status,
  output logic [BYTE_W-1:0] line_ctrl,
  output logic [BYTE_W-1:0] modem_ctrl,
  output logic [DIV_W-1:0]  divisor
);
  logic [EN_W-1:0]   ien_w;
  logic [LS_W-1:0]   lst_w;
  logic [BYTE_W-1:0] hold_w;
  irq_id_e           id_w;
  logic              data_rd, data_wr;
  logic              unused_hi;

  assign unused_hi = ^bus_wdata[DATA_W-1:DIV_W];
  assign data_rd   = bus_rd && (bus_addr == A_DATA);
  assign data_wr   = bus_wr && (bus_addr == A_DATA);

  uart_rf_ctrl #(.BYTE_W(BYTE_W), .DIV_W(DIV_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .wr(bus_wr), .addr(bus_addr),
    .wdata(bus_wdata[DIV_W-1:0]), .ien(ien_w), .lctl(line_ctrl),
    .mctl(modem_ctrl), .div(divisor)
  );

  uart_rf_rx #(.BYTE_W(BYTE_W)) u_rx (
    .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_data(rx_data),
    .pe_stb(rx_parity_err), .fe_stb(rx_frame_err), .brk_stb(rx_break),
    .data_rd(data_rd), .hold(hold_w), .lst(lst_w)
  );

  uart_rf_irq u_irq (
    .ien(ien_w), .lst(lst_w), .mdm_delta(modem_status[3:0]),
    .id(id_w), .irq(irq)
  );

  assign rx_ready = ~lst_w[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_valid <= 1'b0;
      tx_data  <= '0;
    end else begin
      tx_valid <= data_wr;
      if (data_wr) tx_data <= bus_wdata[BYTE_W-1:0];
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_rd) begin
      unique case (bus_addr)
        A_DATA:  bus_rdata[BYTE_W-1:0] = hold_w;
        A_IID:   bus_rdata[2:0]        = id_w;
        A_LST:   bus_rdata[LS_W-1:0]   = lst_w;
        A_MST:   bus_rdata[BYTE_W-1:0] = modem_status;
        default: bus_rdata             = '0;
      endcase
    end
  end
endmodule

// File: rtl/uart_regfile_chk.sv
module uart_regfile_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       bus_wr,
  input logic       bus_rd,
  input logic [2:0] bus_addr,
  input logic [7:0] wbyte,
  input logic       tx_valid,
  input logic [7:0] tx_data,
  input logic       rx_valid,
  input logic       rx_ready,
  input logic       irq,
  input logic [2:0] id,
  input logic [6:0] lst
);
  AST_TX_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == 3'd0) |=> (tx_valid && tx_data == $past(wbyte))); // R3
  AST_TX_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_wr && bus_addr == 3'd0) |=> !tx_valid); // R3
  AST_RX_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_ready); // R4
  AST_RD_FREES: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr == 3'd0 && !rx_valid) |=> rx_ready); // R4
  AST_OVERRUN: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && !rx_ready) |=> lst[1]); // R5
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (|lst[4:1]) |=> ((lst[4:1] & $past(lst[4:1])) == $past(lst[4:1]))); // R6
  AST_IRQ_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    irq == (id != 3'b001)); // R9
endmodule

bind uart_regfile uart_regfile_chk u_chk (
  .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
  .bus_addr(bus_addr), .wbyte(bus_wdata[7:0]), .tx_valid(tx_valid),
  .tx_data(tx_data), .rx_valid(rx_valid), .rx_ready(rx_ready),
  .irq(irq), .id(id_w), .lst(lst_w)
);

// File: tb/sim_uart_regfile.sv
module sim_uart_regfile;
  logic        clk, rst_n, bus_wr, bus_rd, irq, tx_valid, rx_valid, rx_ready;
  logic        rx_parity_err, rx_frame_err, rx_break;
  logic [2:0]  bus_addr;
  logic [31:0] bus_wdata, bus_rdata;
  logic [7:0]  tx_data, rx_data, modem_status, line_ctrl, modem_ctrl;
  logic [15:0] divisor;
  int errs = 0, checks = 0;
  bit done = 0;

  uart_regfile u0 (.*);

  initial clk = 0;
  always #5 clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk); bus_rd = 1; bus_addr = a; #1 d = bus_rdata;
    @(negedge clk); bus_rd = 0;
  endtask

  task automatic rx(input logic [7:0] b);
    @(negedge clk); rx_valid = 1; rx_data = b;
    @(negedge clk); rx_valid = 0;
  endtask

  // {op, addr, data, expected}; op 0 write, 1 read-compare, 2 receive, 3 irq-compare
  localparam int NV = 24;
  localparam logic [47:0] VEC [NV] = '{
    {4'd1, 4'd5, 8'h00, 32'h60}, // R1
    {4'd1, 4'd2, 8'h00, 32'h01}, // R1
    {4'd2, 4'd0, 8'h5A, 32'h00},
    {4'd1, 4'd5, 8'h00, 32'h61}, // R4
    {4'd1, 4'd0, 8'h00, 32'h5A}, // R4
    {4'd1, 4'd5, 8'h00, 32'h60}, // R4
    {4'd0, 4'd1, 8'h01, 32'h00},
    {4'd1, 4'd1, 8'h00, 32'h00}, // R2
    {4'd1, 4'd2, 8'h00, 32'h01}, // R8
    {4'd2, 4'd0, 8'h33, 32'h00},
    {4'd1, 4'd2, 8'h00, 32'h04}, // R8
    {4'd3, 4'd0, 8'h00, 32'h01}, // R9
    {4'd2, 4'd0, 8'h44, 32'h00},
    {4'd1, 4'd5, 8'h00, 32'h63}, // R5
    {4'd1, 4'd2, 8'h00, 32'h04}, // R8
    {4'd0, 4'd1, 8'h05, 32'h00},
    {4'd1, 4'd2, 8'h00, 32'h06}, // R8
    {4'd1, 4'd0, 8'h00, 32'h44}, // R5
    {4'd1, 4'd5, 8'h00, 32'h62}, // R6
    {4'd1, 4'd2, 8'h00, 32'h06}, // R8
    {4'd0, 4'd1, 8'h02, 32'h00},
    {4'd1, 4'd2, 8'h00, 32'h02}, // R8
    {4'd0, 4'd1, 8'h08, 32'h00},
    {4'd3, 4'd0, 8'h00, 32'h00}  // R9
  };

  initial begin
    #1_000_000;
    if (!done) begin
      errs++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    rst_n = 0; bus_wr = 0; bus_rd = 0; bus_addr = 0; bus_wdata = 0;
    rx_valid = 0; rx_data = 0; rx_parity_err = 0; rx_frame_err = 0;
    rx_break = 0; modem_status = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 irq", {31'b0, irq}, 0);
    chk("R1 rx_ready", {31'b0, rx_ready}, 1);
    chk("R1 line_ctrl", {24'b0, line_ctrl}, 0);

    for (int i = 0; i < NV; i++) begin
      case (VEC[i][47:44])
        4'd0: wr(VEC[i][42:40], {24'b0, VEC[i][39:32]});
        4'd1: begin rd(VEC[i][42:40], v); chk("R-table read", v, VEC[i][31:0]); end
        4'd2: rx(VEC[i][39:32]);
        default: begin @(negedge clk); chk("R9 table irq", {31'b0, irq}, VEC[i][31:0]); end
      endcase
    end

    // R10 and modem-status priority level
    modem_status = 8'h81;
    @(negedge clk);
    rd(3'd6, v); chk("R10 modem read", v, 32'h81);
    rd(3'd2, v); chk("R8 modem id", v, 32'h0);
    chk("R9 modem irq", {31'b0, irq}, 1);
    modem_status = 8'h80;
    @(negedge clk);
    chk("R8 upper modem bits ignored", {31'b0, irq}, 0);

    // R3 transmit strobe
    @(negedge clk); bus_wr = 1; bus_addr = 0; bus_wdata = 32'h1A5;
    @(negedge clk); bus_wr = 0;
    chk("R3 tx_valid", {31'b0, tx_valid}, 1);
    chk("R3 tx_data", {24'b0, tx_data}, 32'hA5);
    @(negedge clk);
    chk("R3 single pulse", {31'b0, tx_valid}, 0);
    rd(3'd5, v);
    chk("R3 no tx on read", {31'b0, tx_valid}, 0);

    // R2 configuration outputs and zero readback
    wr(3'd3, 32'hFF03); chk("R2 line_ctrl", {24'b0, line_ctrl}, 32'h03);
    wr(3'd4, 32'h0002); chk("R2 modem_ctrl", {24'b0, modem_ctrl}, 32'h02);
    wr(3'd7, 32'hAB1234); chk("R2 divisor", {16'b0, divisor}, 32'h1234);
    rd(3'd3, v); chk("R2 lcr reads zero", v, 0);
    rd(3'd7, v); chk("R2 div reads zero", v, 0);

    // R7 writes to read-only words
    wr(3'd5, 32'h0); wr(3'd2, 32'h7); wr(3'd6, 32'h0);
    rd(3'd5, v); chk("R7 line status kept", v, 32'h62);
    rd(3'd6, v); chk("R7 modem status kept", v, 32'h80);
    wr(3'd1, 32'h0);
    rd(3'd2, v); chk("R7 id kept", v, 32'h1);

    // R6 error strobes, sticky across reads
    @(negedge clk); rx_parity_err = 1; rx_frame_err = 1; rx_break = 1;
    @(negedge clk); rx_parity_err = 0; rx_frame_err = 0; rx_break = 0;
    rd(3'd5, v); chk("R6 all errors", v, 32'h7E);
    rd(3'd5, v); chk("R6 sticky", v, 32'h7E);

    // R1 reset clears everything back
    @(negedge clk); rst_n = 0;
    @(negedge clk); rst_n = 1;
    @(negedge clk);
    rd(3'd5, v); chk("R1 line status after reset", v, 32'h60);
    chk("R1 divisor after reset", {16'b0, divisor}, 0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule